// File: doc/BRIEF.md
# Multi-Level Trap Entry Sequencer

This block carries out the entry half of trap handling for a processor that nests traps by level. The core offers a trap on a valid/ready request channel carrying a 9-bit trap type, together with the values the trap must preserve: condition codes, address-space identifier, current and next program counters, and the count of windows still free for saving. On acceptance the block checks the trap level and raises it. It saves a packed copy of the processor state into a per-level register stack and moves the processor state word to the global register set that matches the trap class. For window traps it also moves the window pointer. One cycle later it presents a redirect: the new trap base value as the next program counter, and that value plus four as the one after.

The trap level, processor state word, window pointer and trap base register are held inside the block and shown on plain outputs. A read port lets the rest of the core (or a trap-return unit outside this block) look at any stack entry. Back-pressure rule: a request moves only in a cycle where `trap_valid` and `trap_ready` are both high. `trap_ready` drops for exactly the cycle in which the redirect is presented, so a request held high across that cycle is taken once. When the level is already at the maximum, the request is still accepted but raises a sticky error and changes no state.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the trap level is 0, the state word equals `RST_PSTATE`, the window pointer is 0, `err_o` and `redir_valid` are low and `trap_ready` is high.
- R2: A request is taken only on a clock edge where `trap_valid` and `trap_ready` are both high. `redir_valid` is high for exactly the following cycle, and `trap_ready` is low during that cycle, so a request held high is taken once.
- R3: A request taken while the level is at or above `MAXTL` sets `err_o`, which stays high until reset. No redirect is raised, and the level, state word, window pointer and stack are left unchanged.
- R4: A request taken while the level is below `MAXTL`-1 raises the level by one and leaves bit 5 (reduced-state) of the state word as it was.
- R5: A request taken at level `MAXTL`-1 sets state word bit 5 and raises the level to `MAXTL`.
- R6: The saved state of the new level holds ccr in bits 39:32, asi in bits 31:24, zero in 23:20, (state word AND 0xF3F) in 19:8 and the window pointer zero-extended in 7:0. The state word used is the one before entry, but with bit 5 already set when R5 applies.
- R7: The stack entry for the new level, read by placing that level on `rd_lvl`, returns the presented pc, npc and trap type.
- R8: Every entry sets state word bits 4 (FP enable) and 2 (privileged). It sets exactly one of bits 11 (interrupt globals), 10 (MMU globals) and 0 (alternate globals) and clears the other two. Bit 11 is used for type 0x060, bit 10 for types 0x008, 0x030 and 0x064 to 0x06F, and bit 0 for every other type.
- R9: Type 0x024 (clean window) moves the window pointer to cwp-1, modulo `NWIN`.
- R10: A type with (tt AND 0x1C0) = 0x080 (spill) moves the window pointer to cwp-cansave-2, modulo `NWIN`. A type with (tt AND 0x1C0) = 0x0C0 (fill) moves it to cwp+1, modulo `NWIN`.
- R11: `redir_pc` equals the trap base register with bits 4:0 cleared, bit 14 set when the new level is above 1, and the trap type in bits 13:5. Bits above 14 are kept.
- R12: `redir_npc` equals `redir_pc` + 4.
- R13: Trap types not named in R9 or R10 leave the window pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request offered |
| trap_ready | output | 1 | Block can take a request this cycle |
| trap_type | input | 9 | Trap type of the request |
| ccr_i | input | 8 | Condition codes to save |
| asi_i | input | 8 | Address-space identifier to save |
| cansave_i | input | CW | Windows free for saving, used by spill |
| pc_i | input | AW | Program counter to save |
| npc_i | input | AW | Next program counter to save |
| tl_o | output | LW | Current trap level |
| pstate_o | output | 12 | Current processor state word |
| cwp_o | output | CW | Current window pointer |
| err_o | output | 1 | Sticky error: trap taken at maximum level |
| redir_valid | output | 1 | Redirect presented this cycle |
| redir_pc | output | AW | New program counter (trap base register) |
| redir_npc | output | AW | New next program counter |
| rd_lvl | input | LW | Stack level to read (1 to MAXTL) |
| rd_tstate | output | 40 | Saved packed state at `rd_lvl` |
| rd_tpc | output | AW | Saved pc at `rd_lvl` |
| rd_tnpc | output | AW | Saved npc at `rd_lvl` |
| rd_tt | output | 9 | Saved trap type at `rd_lvl` |

## Verification
The bench builds the block with `MAXTL` = 3, so three nested traps reach the reduced-state step and a fourth reaches the error state within a handful of cycles. It uses `NWIN` = 6, a window count that is not a power of two, so clean-window, spill and fill wrap-around exercise the true modulo path rather than plain bit truncation. The reset state word is set to 0x0CA, which has bits 7:6 set, so the 0xF3F mask in the saved state can be seen to drop them. The reset trap base has all low 15 bits set, which shows that they are cleared.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam int PSW = 12;

  // State word bit positions
  localparam int PS_AG   = 0;
  localparam int PS_PRIV = 2;
  localparam int PS_PEF  = 4;
  localparam int PS_RED  = 5;
  localparam int PS_MG   = 10;
  localparam int PS_IG   = 11;

  localparam logic [PSW-1:0] PS_SAVE_MASK = 12'hF3F;

  // Trap type codes and class decode
  localparam logic [8:0] TT_INTVEC     = 9'h060;
  localparam logic [8:0] TT_IFAULT     = 9'h008;
  localparam logic [8:0] TT_DFAULT     = 9'h030;
  localparam logic [8:0] TT_MMU_LO     = 9'h064;
  localparam logic [8:0] TT_MMU_HI     = 9'h06F;
  localparam logic [8:0] TT_CLEANWIN   = 9'h024;
  localparam logic [8:0] TT_CLASS_MASK = 9'h1C0;
  localparam logic [8:0] TT_SPILL_CLS  = 9'h080;
  localparam logic [8:0] TT_FILL_CLS   = 9'h0C0;

  typedef enum logic [1:0] {GS_ALT, GS_MMU, GS_INTR} gset_e;
  typedef enum logic [1:0] {WK_NONE, WK_CLEAN, WK_SPILL, WK_FILL} wkind_e;

  typedef struct packed {
    logic [7:0]     ccr;
    logic [7:0]     asi;
    logic [3:0]     rsv;
    logic [PSW-1:0] ps;
    logic [7:0]     win;
  } tstate_t;

  function automatic gset_e gset_of(input logic [8:0] tt);
    if (tt == TT_INTVEC)
      return GS_INTR;
    else if (tt == TT_IFAULT || tt == TT_DFAULT || (tt >= TT_MMU_LO && tt <= TT_MMU_HI))
      return GS_MMU;
    else
      return GS_ALT;
  endfunction

  function automatic wkind_e wkind_of(input logic [8:0] tt);
    if (tt == TT_CLEANWIN)
      return WK_CLEAN;
    else if ((tt & TT_CLASS_MASK) == TT_SPILL_CLS)
      return WK_SPILL;
    else if ((tt & TT_CLASS_MASK) == TT_FILL_CLS)
      return WK_FILL;
    else
      return WK_NONE;
  endfunction

endpackage

// File: rtl/tel_level.sv
module tel_level #(
  parameter int MAXTL = 5,
  parameter int LW    = $clog2(MAXTL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  output logic [LW-1:0] tl_q,
  output logic [LW-1:0] nl,
  output logic          fault,
  output logic          red
);

  localparam logic [LW-1:0] TL_MAX  = LW'(MAXTL);
  localparam logic [LW-1:0] TL_LAST = LW'(MAXTL - 1);

  assign fault = (tl_q >= TL_MAX);
  assign red   = !fault && (tl_q >= TL_LAST);
  assign nl    = tl_q + LW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      tl_q <= '0;
    else if (take && !fault)
      tl_q <= nl;
  end

endmodule

// File: rtl/tel_pstate_cwp.sv
module tel_pstate_cwp
  import trap_entry_pkg::*;
#(
  parameter int             NWIN       = 8,
  parameter int             CW         = $clog2(NWIN),
  parameter logic [PSW-1:0] RST_PSTATE = 12'h000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic           red,
  input  logic [8:0]     tt,
  input  logic [CW-1:0]  cansave,
  output logic [PSW-1:0] ps_q,
  output logic [PSW-1:0] ps_saved,
  output logic [CW-1:0]  cwp_q
);

  localparam int            SW       = CW + 2;
  localparam logic [SW-1:0] SP_BIAS  = SW'(2 * NWIN - 2);
  localparam logic [SW-1:0] WIN_MOD  = SW'(NWIN);
  localparam logic [CW-1:0] WIN_LAST = CW'(NWIN - 1);

  logic [PSW-1:0] ps_next;
  logic [CW-1:0]  cwp_next;
  logic [SW-1:0]  sp_sum;

  always_comb begin
    ps_saved = ps_q;
    if (red)
      ps_saved[PS_RED] = 1'b1;
    ps_next          = ps_saved;
    ps_next[PS_PEF]  = 1'b1;
    ps_next[PS_PRIV] = 1'b1;
    ps_next[PS_AG]   = 1'b0;
    ps_next[PS_MG]   = 1'b0;
    ps_next[PS_IG]   = 1'b0;
    case (gset_of(tt))
      GS_INTR: ps_next[PS_IG] = 1'b1;
      GS_MMU:  ps_next[PS_MG] = 1'b1;
      default: ps_next[PS_AG] = 1'b1;
    endcase
  end

  always_comb begin
    sp_sum   = {2'b00, cwp_q} + SP_BIAS - {2'b00, cansave};
    cwp_next = cwp_q;
    case (wkind_of(tt))
      WK_CLEAN: cwp_next = (cwp_q == '0) ? WIN_LAST : cwp_q - CW'(1);
      WK_SPILL: cwp_next = CW'(sp_sum % WIN_MOD);
      WK_FILL:  cwp_next = (cwp_q == WIN_LAST) ? '0 : cwp_q + CW'(1);
      default:  cwp_next = cwp_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q  <= RST_PSTATE;
      cwp_q <= '0;
    end else if (commit) begin
      ps_q  <= ps_next;
      cwp_q <= cwp_next;
    end
  end

endmodule

// File: rtl/tel_stack.sv
module tel_stack #(
  parameter int DEPTH = 5,
  parameter int LW    = $clog2(DEPTH + 1),
  parameter int AW    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [LW-1:0] wlvl,
  input  logic [39:0]   wtstate,
  input  logic [AW-1:0] wpc,
  input  logic [AW-1:0] wnpc,
  input  logic [8:0]    wtt,
  input  logic [LW-1:0] rlvl,
  output logic [39:0]   rtstate,
  output logic [AW-1:0] rpc,
  output logic [AW-1:0] rnpc,
  output logic [8:0]    rtt
);

  logic [39:0]   ts_mem  [DEPTH];
  logic [AW-1:0] pc_mem  [DEPTH];
  logic [AW-1:0] npc_mem [DEPTH];
  logic [8:0]    tt_mem  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [LW-1:0] MY_LVL = LW'(g + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ts_mem[g]  <= '0;
        pc_mem[g]  <= '0;
        npc_mem[g] <= '0;
        tt_mem[g]  <= '0;
      end else if (we && wlvl == MY_LVL) begin
        ts_mem[g]  <= wtstate;
        pc_mem[g]  <= wpc;
        npc_mem[g] <= wnpc;
        tt_mem[g]  <= wtt;
      end
    end
  end

  always_comb begin
    rtstate = '0;
    rpc     = '0;
    rnpc    = '0;
    rtt     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rlvl == LW'(i + 1)) begin
        rtstate = ts_mem[i];
        rpc     = pc_mem[i];
        rnpc    = npc_mem[i];
        rtt     = tt_mem[i];
      end
    end
  end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int             MAXTL      = 5,
  parameter int             NWIN       = 8,
  parameter int             AW         = 64,
  parameter logic [PSW-1:0] RST_PSTATE = 12'h000,
  parameter logic [AW-1:0]  TBA_RST    = '0,
  localparam int            CW         = $clog2(NWIN),
  localparam int            LW         = $clog2(MAXTL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trap_valid,
  output logic           trap_ready,
  input  logic [8:0]     trap_type,
  input  logic [7:0]     ccr_i,
  input  logic [7:0]     asi_i,
  input  logic [CW-1:0]  cansave_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [AW-1:0]  npc_i,
  output logic [LW-1:0]  tl_o,
  output logic [PSW-1:0] pstate_o,
  output logic [CW-1:0]  cwp_o,
  output logic           err_o,
  output logic           redir_valid,
  output logic [AW-1:0]  redir_pc,
  output logic [AW-1:0]  redir_npc,
  input  logic [LW-1:0]  rd_lvl,
  output logic [39:0]    rd_tstate,
  output logic [AW-1:0]  rd_tpc,
  output logic [AW-1:0]  rd_tnpc,
  output logic [8:0]     rd_tt
);

  logic           take, commit, fault, red;
  logic [LW-1:0]  nl;
  logic [PSW-1:0] ps_saved;
  tstate_t        ts_pack;
  logic [AW-1:0]  tbr_q, tbr_next;
  logic           rv_q, err_q;
  logic [AW-1:0]  npc_q;

  assign trap_ready = !rv_q;
  assign take       = trap_valid && trap_ready;
  assign commit     = take && !fault;

  tel_level #(.MAXTL(MAXTL), .LW(LW)) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .tl_q  (tl_o),
    .nl    (nl),
    .fault (fault),
    .red   (red)
  );

  tel_pstate_cwp #(.NWIN(NWIN), .CW(CW), .RST_PSTATE(RST_PSTATE)) u_pscwp (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .red      (red),
    .tt       (trap_type),
    .cansave  (cansave_i),
    .ps_q     (pstate_o),
    .ps_saved (ps_saved),
    .cwp_q    (cwp_o)
  );

  always_comb begin
    ts_pack.ccr = ccr_i;
    ts_pack.asi = asi_i;
    ts_pack.rsv = '0;
    ts_pack.ps  = ps_saved & PS_SAVE_MASK;
    ts_pack.win = 8'(cwp_o);
  end

  tel_stack #(.DEPTH(MAXTL), .LW(LW), .AW(AW)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (commit),
    .wlvl    (nl),
    .wtstate (ts_pack),
    .wpc     (pc_i),
    .wnpc    (npc_i),
    .wtt     (trap_type),
    .rlvl    (rd_lvl),
    .rtstate (rd_tstate),
    .rpc     (rd_tpc),
    .rnpc    (rd_tnpc),
    .rtt     (rd_tt)
  );

  assign tbr_next = {tbr_q[AW-1:15], (nl > LW'(1)), trap_type, 5'b00000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbr_q <= TBA_RST;
      npc_q <= '0;
      rv_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rv_q <= commit;
      if (commit) begin
        tbr_q <= tbr_next;
        npc_q <= tbr_next + AW'(4);
      end
      if (take && fault)
        err_q <= 1'b1;
    end
  end

  assign redir_valid = rv_q;
  assign redir_pc    = tbr_q;
  assign redir_npc   = npc_q;
  assign err_o       = err_q;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_entry_pkg::*;
#(
  parameter int MAXTL = 5,
  parameter int NWIN  = 8,
  parameter int AW    = 64,
  localparam int CW   = $clog2(NWIN),
  localparam int LW   = $clog2(MAXTL + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trap_valid,
  input logic           trap_ready,
  input logic [8:0]     trap_type,
  input logic [LW-1:0]  tl_o,
  input logic [PSW-1:0] pstate_o,
  input logic [CW-1:0]  cwp_o,
  input logic           err_o,
  input logic           redir_valid,
  input logic [AW-1:0]  redir_pc,
  input logic [AW-1:0]  redir_npc
);

  logic acc;
  assign acc = trap_valid && trap_ready;

  // R2
  acc_gives_one_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && tl_o < LW'(MAXTL) |=> redir_valid && !trap_ready);

  // R3
  err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && tl_o >= LW'(MAXTL) |=> err_o && !redir_valid && $stable(tl_o) && $stable(pstate_o) && $stable(cwp_o));

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R4
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && tl_o < LW'(MAXTL - 1) |=> tl_o == $past(tl_o) + LW'(1) && pstate_o[PS_RED] == $past(pstate_o[PS_RED]));

  // R5
  red_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && tl_o == LW'(MAXTL - 1) |=> pstate_o[PS_RED] && tl_o == LW'(MAXTL));

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tl_o <= LW'(MAXTL));

  // R8
  globals_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> pstate_o[PS_PEF] && pstate_o[PS_PRIV] && $countones({pstate_o[PS_IG], pstate_o[PS_MG], pstate_o[PS_AG]}) == 1);

  // R11
  vector_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && tl_o < LW'(MAXTL) |=> redir_pc[4:0] == 5'b0 && redir_pc[13:5] == $past(trap_type) && redir_pc[14] == (tl_o > LW'(1)));

  // R12
  npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> redir_npc == redir_pc + AW'(4));

endmodule

bind trap_entry_seq trap_entry_chk #(.MAXTL(MAXTL), .NWIN(NWIN), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trap_valid  (trap_valid),
  .trap_ready  (trap_ready),
  .trap_type   (trap_type),
  .tl_o        (tl_o),
  .pstate_o    (pstate_o),
  .cwp_o       (cwp_o),
  .err_o       (err_o),
  .redir_valid (redir_valid),
  .redir_pc    (redir_pc),
  .redir_npc   (redir_npc)
);

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;

  localparam int CLK_PERIOD = 10;
  localparam int MAXTL = 3;
  localparam int NWIN  = 6;
  localparam int AW    = 64;
  localparam int CW    = $clog2(NWIN);
  localparam int LW    = $clog2(MAXTL + 1);
  localparam logic [11:0] RSTPS = 12'h0CA;
  localparam logic [63:0] TBA0  = 64'h0000_0040_0000_7FFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trap_valid = 1'b0;
  logic          trap_ready;
  logic [8:0]    trap_type = '0;
  logic [7:0]    ccr_i = '0, asi_i = '0;
  logic [CW-1:0] cansave_i = '0;
  logic [63:0]   pc_i = '0, npc_i = '0;
  logic [LW-1:0] tl_o;
  logic [11:0]   pstate_o;
  logic [CW-1:0] cwp_o;
  logic          err_o, redir_valid;
  logic [63:0]   redir_pc, redir_npc;
  logic [LW-1:0] rd_lvl = '0;
  logic [39:0]   rd_tstate;
  logic [63:0]   rd_tpc, rd_tnpc;
  logic [8:0]    rd_tt;

  int checks = 0;
  int errors = 0;

  int          m_tl, m_cwp;
  logic [11:0] m_ps;
  logic [63:0] e_ts [1:MAXTL];
  logic [63:0] e_pc [1:MAXTL];
  logic [63:0] e_npc[1:MAXTL];
  logic [8:0]  e_tt [1:MAXTL];

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_seq #(.MAXTL(MAXTL), .NWIN(NWIN), .AW(AW), .RST_PSTATE(RSTPS), .TBA_RST(TBA0)) u0 (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_type(trap_type), .ccr_i(ccr_i), .asi_i(asi_i), .cansave_i(cansave_i),
    .pc_i(pc_i), .npc_i(npc_i), .tl_o(tl_o), .pstate_o(pstate_o), .cwp_o(cwp_o),
    .err_o(err_o), .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_npc(redir_npc),
    .rd_lvl(rd_lvl), .rd_tstate(rd_tstate), .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc), .rd_tt(rd_tt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_ps(input logic [11:0] p, input logic [8:0] tt);
    logic [11:0] r;
    r = (p | 12'h014) & ~12'hC01;
    if (tt == 9'h060) r |= 12'h800;
    else if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) r |= 12'h400;
    else r |= 12'h001;
    return r;
  endfunction

  function automatic int exp_cwp(input int c, input logic [8:0] tt, input int cs);
    if (tt == 9'h024) return (c + NWIN - 1) % NWIN;
    if ((tt & 9'h1C0) == 9'h080) return ((c - cs - 2) % NWIN + NWIN) % NWIN;
    if ((tt & 9'h1C0) == 9'h0C0) return (c + 1) % NWIN;
    return c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trap_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_tl = 0; m_ps = RSTPS; m_cwp = 0;
  endtask

  task automatic check_entry(input int lvl);
    rd_lvl = LW'(lvl);
    #1;
    chk("R6 tstate", {24'h0, rd_tstate}, e_ts[lvl]);
    chk("R7 tpc", rd_tpc, e_pc[lvl]);
    chk("R7 tnpc", rd_tnpc, e_npc[lvl]);
    chk("R7 tt", {55'h0, rd_tt}, {55'h0, e_tt[lvl]});
  endtask

  // One trap through the request channel, checked against the model
  task automatic do_trap(input logic [8:0] tt, input logic [7:0] ccr, input logic [7:0] asi,
                         input int cs, input logic [63:0] pc, input logic [63:0] npc);
    logic [11:0] ps_s;
    logic [63:0] pc_e;
    int nl, cw_old;
    @(negedge clk);
    chk("R2 ready before", {63'h0, trap_ready}, 64'h1);
    trap_valid = 1'b1; trap_type = tt; ccr_i = ccr; asi_i = asi;
    cansave_i = CW'(cs); pc_i = pc; npc_i = npc;
    @(posedge clk);
    @(negedge clk);
    trap_valid = 1'b0;
    if (m_tl >= MAXTL) begin
      chk("R3 err", {63'h0, err_o}, 64'h1);
      chk("R3 no redirect", {63'h0, redir_valid}, 64'h0);
      chk("R3 tl", {60'h0, 4'(tl_o)}, 64'(m_tl));
      chk("R3 pstate", {52'h0, pstate_o}, {52'h0, m_ps});
      chk("R3 cwp", {61'h0, 3'(cwp_o)}, 64'(m_cwp));
      return;
    end
    nl = m_tl + 1;
    ps_s = m_ps;
    if (m_tl == MAXTL - 1) ps_s[5] = 1'b1;
    cw_old = m_cwp;
    pc_e = {TBA0[63:15], (nl > 1), tt, 5'b0};
    e_ts[nl]  = {24'h0, ccr, asi, 4'h0, ps_s & 12'hF3F, 8'(cw_old)};
    e_pc[nl]  = pc; e_npc[nl] = npc; e_tt[nl] = tt;
    m_ps  = exp_ps(ps_s, tt);
    m_cwp = exp_cwp(cw_old, tt, cs);
    m_tl  = nl;
    chk("R2 redir_valid", {63'h0, redir_valid}, 64'h1);
    chk("R2 ready low", {63'h0, trap_ready}, 64'h0);
    if (nl == MAXTL) chk("R5 tl", {60'h0, 4'(tl_o)}, 64'(nl));
    else chk("R4 tl", {60'h0, 4'(tl_o)}, 64'(nl));
    if (nl == MAXTL) chk("R5 red bit", {63'h0, pstate_o[5]}, 64'h1);
    chk("R8 pstate", {52'h0, pstate_o}, {52'h0, m_ps});
    if (exp_cwp(cw_old, tt, cs) == cw_old) chk("R13 cwp", {61'h0, 3'(cwp_o)}, 64'(m_cwp));
    else if (tt == 9'h024) chk("R9 cwp", {61'h0, 3'(cwp_o)}, 64'(m_cwp));
    else chk("R10 cwp", {61'h0, 3'(cwp_o)}, 64'(m_cwp));
    chk("R11 redir_pc", redir_pc, pc_e);
    chk("R12 redir_npc", redir_npc, pc_e + 64'd4);
    check_entry(nl);
    @(negedge clk);
    chk("R2 single pulse", {63'h0, redir_valid}, 64'h0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tl", {60'h0, 4'(tl_o)}, 64'h0);
    chk("R1 pstate", {52'h0, pstate_o}, {52'h0, RSTPS});
    chk("R1 cwp", {61'h0, 3'(cwp_o)}, 64'h0);
    chk("R1 err", {63'h0, err_o}, 64'h0);
    chk("R1 redir_valid", {63'h0, redir_valid}, 64'h0);
    chk("R1 ready", {63'h0, trap_ready}, 64'h1);
  endtask

  // Clean window, spill, MMU miss at last level, then error
  task automatic t_nested();
    do_reset();
    do_trap(9'h024, 8'h5A, 8'h80, 2, 64'h1000, 64'h1004);
    do_trap(9'h0A8, 8'hC3, 8'h11, 3, 64'h2000, 64'h2004);
    do_trap(9'h068, 8'h01, 8'hFE, 0, 64'h3000, 64'h3008);
    do_trap(9'h041, 8'h77, 8'h22, 0, 64'h4000, 64'h4004);
    for (int l = 1; l <= MAXTL; l++) check_entry(l);
    repeat (2) @(negedge clk);
    chk("R3 err sticky", {63'h0, err_o}, 64'h1);
  endtask

  // Fill then interrupt vector, second level sets bit 14
  task automatic t_fill_intr();
    do_reset();
    do_trap(9'h0C5, 8'h10, 8'h20, 1, 64'h5000, 64'h5004);
    do_trap(9'h060, 8'h30, 8'h40, 1, 64'h6000, 64'h6004);
  endtask

  // MMU data fault then spill wrapping below zero
  task automatic t_fault_wrap();
    do_reset();
    do_trap(9'h030, 8'hAA, 8'hBB, 0, 64'h7000, 64'h7004);
    do_trap(9'h0B0, 8'hCC, 8'hDD, 5, 64'h8000, 64'h8004);
  endtask

  // Valid held across the redirect cycle is taken once
  task automatic t_hold();
    do_reset();
    @(negedge clk);
    trap_valid = 1'b1; trap_type = 9'h010; cansave_i = '0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 ready low while held", {63'h0, trap_ready}, 64'h0);
    @(posedge clk);
    @(negedge clk);
    trap_valid = 1'b0;
    chk("R2 taken once", {60'h0, 4'(tl_o)}, 64'h1);
    chk("R2 no second redirect", {63'h0, redir_valid}, 64'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_nested();
    t_fill_intr();
    t_fault_wrap();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule